// File: doc/BRIEF.md
# Priority On-Ramp Lane Light Controller

This block runs the stop/go lights of a freeway on-ramp that has three feeding lanes: a car-pool lane, a right lane and a left lane. Each lane has a switch that reports a waiting car and a pair of lamps, one red and one green. At every decision point the controller gives green to at most one lane with a waiting car and shows red on all other lanes. When no car waits anywhere, every lane shows red.

The car-pool lane has the highest rank. The right lane ranks above the left lane. The car switches are asynchronous and active-low, so each one is inverted and passed through a two-stage synchronizer before arbitration. A green, once given, lasts for `HOLD_TICKS` clock cycles. After that the controller arbitrates again, and it may give the same lane another period. While every lane shows red, the controller arbitrates on every cycle. All six lamp drive lines are registered and active-low.

Top module: `ramp_light_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every lane shows red: each `*_red_n` is 0 and each `*_grn_n` is 1.
- R2: In every cycle each lane lights exactly one of its two lamps (`*_red_n` differs from `*_grn_n`), and no more than one `*_grn_n` is 0.
- R3: When a decision is taken and the synchronized car-pool request is set, the car-pool lane is given green, whatever the other two lanes request.
- R4: When a decision is taken, the car-pool request is clear and both the right and left requests are set, the right lane is given green.
- R5: When a decision is taken and only the left lane requests, the left lane is given green.
- R6: When a decision is taken and no lane requests, all three lanes show red. A lane never gets green without its own synchronized request.
- R7: Polarity. A car input at 0 means a car is present and 1 means the lane is empty. A lamp output at 0 lights the lamp.
- R8: A change on a car input reaches the lamps at the third rising edge after it: two synchronizer stages, then the registered decision and lamp stage.
- R9: A green stays on for at least `HOLD_TICKS` cycles. It stays on even if its car leaves or a higher-ranked lane starts to request during that time.
- R10: When a green period ends, the controller arbitrates again. If the same lane is still the highest-ranked requester, it keeps green with no red gap.
- R11: While all lanes show red, a new request is arbitrated at once, with no hold wait, and so appears with the R8 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_pool_n | input | 1 | Car-pool lane sensor, 0 = car waiting |
| car_left_n | input | 1 | Left lane sensor, 0 = car waiting |
| car_right_n | input | 1 | Right lane sensor, 0 = car waiting |
| pool_red_n | output | 1 | Car-pool red lamp, 0 = lit |
| pool_grn_n | output | 1 | Car-pool green lamp, 0 = lit |
| left_red_n | output | 1 | Left lane red lamp, 0 = lit |
| left_grn_n | output | 1 | Left lane green lamp, 0 = lit |
| right_red_n | output | 1 | Right lane red lamp, 0 = lit |
| right_grn_n | output | 1 | Right lane green lamp, 0 = lit |

## Verification
The assertions check, on every cycle, the following properties:
- the lamp-pair exclusivity and single-green rules;
- the state after reset;
- that every new green follows from its own synchronized request;
- that no new green goes against the ranking of the other requests;
- that no green ends before `HOLD_TICKS` cycles.

Only the bench scenarios can show the three-edge input latency. They also show that a higher-ranked arrival waits out a running green, that the same lane is granted again with no gap, that all lamps go red once the cars leave, and that an idle controller responds at once.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  // Lane index doubles as rank: a lower index wins arbitration.
  localparam int LANES = 3;
  typedef enum logic [1:0] {
    LANE_POOL  = 2'd0,
    LANE_RIGHT = 2'd1,
    LANE_LEFT  = 2'd2
  } lane_e;
  typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
  parameter int WIDTH      = 3,
  parameter int STAGES     = 2,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] pipe [STAGES];
  logic [WIDTH-1:0] level_in;

  generate
    if (ACTIVE_LOW) begin : g_inv
      assign level_in = ~raw_in;
    end else begin : g_pass
      assign level_in = raw_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= level_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/ramp_arbiter.sv
module ramp_arbiter #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // Fixed rank: bit 0 highest.
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ramp_phase_ctrl.sv
module ramp_phase_ctrl #(
  parameter int N          = 3,
  parameter int HOLD_TICKS = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] arb_grant,
  output logic [N-1:0] grant_next,
  output logic [N-1:0] grant_cur
);
  localparam int CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] hold_cnt;
  logic             decide;

  assign decide     = (grant_cur == '0) || (hold_cnt == LAST);
  assign grant_next = decide ? arb_grant : grant_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_cur <= '0;
      hold_cnt  <= '0;
    end else begin
      grant_cur <= grant_next;
      hold_cnt  <= decide ? '0 : hold_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ramp_lamp_drive.sv
module ramp_lamp_drive #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] grant_next,
  output logic [N-1:0] red_n,
  output logic [N-1:0] grn_n
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          red_n[i] <= 1'b0;
          grn_n[i] <= 1'b1;
        end else begin
          red_n[i] <= grant_next[i];
          grn_n[i] <= ~grant_next[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ramp_light_ctrl.sv
module ramp_light_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic car_pool_n,
  input  logic car_left_n,
  input  logic car_right_n,
  output logic pool_red_n,
  output logic pool_grn_n,
  output logic left_red_n,
  output logic left_grn_n,
  output logic right_red_n,
  output logic right_grn_n
);
  import ramp_pkg::*;

  lane_vec_t raw_n, req_s, arb_grant, grant_next, grant_cur, red_n_v, grn_n_v;

  assign raw_n[LANE_POOL]  = car_pool_n;
  assign raw_n[LANE_RIGHT] = car_right_n;
  assign raw_n[LANE_LEFT]  = car_left_n;

  ramp_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b1)) u_sync (
    .clk(clk), .rst(rst), .raw_in(raw_n), .sync_out(req_s)
  );

  ramp_arbiter #(.N(LANES)) u_arb (
    .req(req_s), .grant(arb_grant)
  );

  ramp_phase_ctrl #(.N(LANES), .HOLD_TICKS(HOLD_TICKS)) u_phase (
    .clk(clk), .rst(rst), .arb_grant(arb_grant),
    .grant_next(grant_next), .grant_cur(grant_cur)
  );

  ramp_lamp_drive #(.N(LANES)) u_lamp (
    .clk(clk), .rst(rst), .grant_next(grant_next),
    .red_n(red_n_v), .grn_n(grn_n_v)
  );

  assign pool_red_n  = red_n_v[LANE_POOL];
  assign pool_grn_n  = grn_n_v[LANE_POOL];
  assign right_red_n = red_n_v[LANE_RIGHT];
  assign right_grn_n = grn_n_v[LANE_RIGHT];
  assign left_red_n  = red_n_v[LANE_LEFT];
  assign left_grn_n  = grn_n_v[LANE_LEFT];
endmodule

// File: rtl/ramp_light_chk.sv
module ramp_light_chk #(
  parameter int HOLD_TICKS = 16
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] req_s,
  input logic [2:0] red_n,
  input logic [2:0] grn_n
);
  localparam int HW = $clog2(HOLD_TICKS + 1) + 1;

  logic [2:0]    green, prev_green;
  logic [HW-1:0] held;

  assign green = ~grn_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_green <= '0;
      held       <= '0;
    end else begin
      prev_green <= green;
      if (green != prev_green)           held <= HW'(1);
      else if (held < HW'(HOLD_TICKS))   held <= held + 1'b1;
    end
  end

  a_r2_one_green: assert property (@(posedge clk) disable iff (rst)
    $countones(green) <= 1);
  a_r2_lane_pair: assert property (@(posedge clk) disable iff (rst)
    (red_n ^ grn_n) == 3'b111);
  a_r1_reset_red: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (red_n == 3'b000 && grn_n == 3'b111));
  a_r3_pool_first: assert property (@(posedge clk) disable iff (rst)
    $fell(grn_n[1]) || $fell(grn_n[2]) |-> !$past(req_s[0]));
  a_r4_right_over_left: assert property (@(posedge clk) disable iff (rst)
    $fell(grn_n[2]) |-> !$past(req_s[1]));
  a_r6_grant_needs_car: assert property (@(posedge clk) disable iff (rst)
    (($fell(grn_n) & ~$past(req_s)) == 3'b000));
  a_r9_min_hold: assert property (@(posedge clk) disable iff (rst)
    (prev_green != 3'b000 && green != prev_green) |-> held >= HW'(HOLD_TICKS));
endmodule

bind ramp_light_ctrl ramp_light_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk(clk), .rst(rst), .req_s(req_s), .red_n(red_n_v), .grn_n(grn_n_v)
);

// File: tb/ramp_light_ctrl_test.sv
module ramp_light_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_pool_n = 1'b1, car_left_n = 1'b1, car_right_n = 1'b1;
  logic pool_red_n, pool_grn_n, left_red_n, left_grn_n, right_red_n, right_grn_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string cyc_tag = "R2";

  // model: lane -1 none, 0 pool, 1 right, 2 left
  int m_lane = -1;
  int m_cnt  = 0;
  logic [2:0] m_s1 = '0, m_s2 = '0;  // {left,right,pool}, logical

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_light_ctrl #(.SYNC_STAGES(2), .HOLD_TICKS(HOLD)) uut (
    .clk(clk), .rst(rst),
    .car_pool_n(car_pool_n), .car_left_n(car_left_n), .car_right_n(car_right_n),
    .pool_red_n(pool_red_n), .pool_grn_n(pool_grn_n),
    .left_red_n(left_red_n), .left_grn_n(left_grn_n),
    .right_red_n(right_red_n), .right_grn_n(right_grn_n)
  );

  function automatic int pick(logic [2:0] r);
    if (r[0]) return 0;
    if (r[1]) return 1;
    if (r[2]) return 2;
    return -1;
  endfunction

  function automatic logic [5:0] exp_lamps(int lane);
    case (lane)
      0:       return 6'b10_01_01;
      1:       return 6'b01_10_01;
      2:       return 6'b01_01_10;
      default: return 6'b01_01_01;
    endcase
  endfunction

  function automatic logic [5:0] lamps();
    return {pool_red_n, pool_grn_n, right_red_n, right_grn_n, left_red_n, left_grn_n};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_lane = -1; m_cnt = 0;
    end else begin
      logic [2:0] used;
      used = m_s2;
      m_s2 = m_s1;
      m_s1 = {~car_left_n, ~car_right_n, ~car_pool_n};
      if (m_lane < 0 || m_cnt == HOLD - 1) begin
        m_lane = pick(used);
        m_cnt  = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s lamps actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_lane(input int lane, input string tag);
    check(lamps() == exp_lamps(lane), tag, lamps(), exp_lamps(lane));
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2 and model comparison every cycle
  always @(negedge clk) begin
    if (!rst && !done) check(lamps() == exp_lamps(m_lane), cyc_tag, lamps(), exp_lamps(m_lane));
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_lane(-1, "R1");              // reset state, red lit
    rst = 1'b0;
    step(1);
    expect_lane(-1, "R1");
    // R5/R8/R7: left alone, latency of three edges
    car_left_n = 1'b0;
    step(2);
    expect_lane(-1, "R8");
    step(1);
    expect_lane(2, "R5");
    check(left_grn_n == 1'b0 && left_red_n == 1'b1, "R7",
          {4'b0, left_red_n, left_grn_n}, 6'b000010);
    // R9: pool arrives mid-green, left keeps it
    car_pool_n = 1'b0;
    step(1);
    expect_lane(2, "R9");
    step(3);
    expect_lane(2, "R9");
    step(1);
    expect_lane(0, "R3");
    // R10: all waiting, pool re-granted without gap
    car_right_n = 1'b0;
    cyc_tag = "R10";
    step(HOLD);
    expect_lane(0, "R10");
    // R4: pool leaves, right beats left
    car_pool_n = 1'b1;
    cyc_tag = "R4";
    step(HOLD);
    expect_lane(1, "R4");
    // R6: everybody leaves
    car_right_n = 1'b1;
    car_left_n  = 1'b1;
    cyc_tag = "R6";
    step(HOLD);
    expect_lane(-1, "R6");
    step(3);
    expect_lane(-1, "R6");
    // R11: idle, new right car served after three edges
    car_right_n = 1'b0;
    cyc_tag = "R11";
    step(2);
    expect_lane(-1, "R11");
    step(1);
    expect_lane(1, "R11");
    // R1: reset in the middle of a green
    rst = 1'b1;
    step(1);
    expect_lane(-1, "R1");
    rst = 1'b0;
    cyc_tag = "R2";
    step(1);
    expect_lane(-1, "R1");
    step(2);
    expect_lane(1, "R8");
    car_right_n = 1'b1;
    step(HOLD + 4);
    expect_lane(-1, "R6");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule